// File: doc/BRIEF.md
# Residue-Checked Arithmetic and Logic Unit

This unit performs 16-bit arithmetic and bitwise logic on operands that each carry a 4-bit residue check symbol (modulus 15). The residue of a word is the ones'-complement sum of its four nibbles, and the codes 0000 and 1111 both stand for zero. Arithmetic is ones'-complement: the carry out of the top bit wraps back into bit 0. Because 15 divides 2^16 - 1, the residue of such a sum is the ones'-complement sum of the operand residues.

For every operation whose result residue follows from the operand residues, the unit predicts the result check symbol. It then compares that prediction with a residue it computes from the result data, and reports the outcome on a two-rail error pair. This is the secure mode. It covers addition, subtraction, and the logic functions "pass A", "pass B", all zeros and all ones.

Every other logic function (AND, OR, XOR and the rest) runs in insecure mode. The comparison is switched off, the pair is held at "good", and the result is re-encoded with the residue computed from its own data. A test input XORs a mask into the result data before the checking logic, so that data faults can be injected. All outputs are registered and appear one clock after the inputs.

Top module: `rsd_alu`

## Requirements
- R1: While `rst_n` is low, at each rising clock edge `y_dat`, `y_chk` and `y_cout` are cleared and `err_rail` becomes 2'b10 (good).
- R2: With `op_mode`=0 and `fsel[0]`=0, the next-cycle `y_dat` is the ones'-complement sum A+B, with the carry out of bit 15 added back into bit 0. `y_cout` is that carry.
- R3: With `op_mode`=0 and `fsel[0]`=1, the next-cycle `y_dat` is A + ~B, using the same end-around carry, and `y_cout` is the carry out of bit 15. In mode 0, `fsel[3:1]` has no effect on any output.
- R4: With `op_mode`=1, bit i of the next-cycle `y_dat` is `fsel[{a_dat[i], b_dat[i]}]`, and `y_cout` is 0. The code values are: 4'b1100 passes A, 4'b1010 passes B, 4'b0000 gives all zeros, 4'b1111 gives all ones, 4'b1000 gives AND, 4'b1110 gives OR, and 4'b0110 gives XOR.
- R5: In secure operations, `y_chk` is the predicted symbol, and every addition below is a 4-bit ones'-complement addition with end-around carry. For add it is a_chk + b_chk. For subtract it is a_chk + ~b_chk. For pass A it is `a_chk`, for pass B it is `b_chk`, and for all zeros or all ones it is 4'b0000.
- R6: In insecure operations (`op_mode`=1 with any `fsel` other than 1100, 1010, 0000 or 1111), `y_chk` is the residue of the output `y_dat` in canonical form, from 0 to 14. It is never 4'b1111.
- R7: A secure operation on operands whose checks match their data, with `fault_mask`=0, gives `err_rail`=2'b10.
- R8: A secure operation on valid operands with exactly one bit set in `fault_mask` flips that bit of `y_dat` and gives `err_rail`=2'b01.
- R9: A secure operation in which an operand check symbol does not match its data residue, with `fault_mask`=0, gives `err_rail`=2'b01.
- R10: An insecure operation gives `err_rail`=2'b10 whatever the operands and `fault_mask`. The result data includes the mask, and the check symbol is re-encoded from that data.
- R11: The comparison treats 4'b1111 as equal to 4'b0000. For example, adding operands with checks 7 and 8 gives `y_chk`=4'b1111 together with a good indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_dat | input | 16 | Operand A data |
| a_chk | input | 4 | Operand A residue check |
| b_dat | input | 16 | Operand B data |
| b_chk | input | 4 | Operand B residue check |
| op_mode | input | 1 | 0 arithmetic, 1 logic |
| fsel | input | 4 | Arithmetic op (bit 0) or logic truth table |
| fault_mask | input | 16 | Test mask XORed into the result data |
| y_dat | output | 16 | Registered result data |
| y_chk | output | 4 | Registered result check symbol |
| y_cout | output | 1 | Registered carry out of bit 15 |
| err_rail | output | 2 | Two-rail indicator, 10 good, 01 error |

## Verification
Random additions and subtractions of valid codewords exercise the prediction and comparison over the whole data range. Directed operands target the end-around carry, the negative-zero result 0xFFFF, and the 1111/0000 equivalence, so that carry handling and residue normalization are told apart. Single-bit masks on every result bit, and corrupted operand checks, separate detection in secure mode from the forced "good" of insecure mode. The logic truth tables are tried on the four preserving functions and on AND, OR and XOR, which separates the prediction path from the re-encoding path.

// File: rtl/rsd_pkg.sv
// Shared definitions for the residue-checked ALU.
// Assumes a 4-bit residue symbol (modulus 15); data width is a multiple of 4.
package rsd_pkg;
    localparam int RC_CW = 4;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } op_mode_e;

    // Logic codes whose result residue follows from the operands.
    localparam logic [3:0] FN_PASS_A = 4'b1100;
    localparam logic [3:0] FN_PASS_B = 4'b1010;
    localparam logic [3:0] FN_ZERO   = 4'b0000;
    localparam logic [3:0] FN_ONES   = 4'b1111;

    // Ones'-complement addition of two symbols with end-around carry.
    function automatic logic [RC_CW-1:0] rc_ones_add(input logic [RC_CW-1:0] x,
                                                     input logic [RC_CW-1:0] y);
        logic [RC_CW:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[RC_CW-1:0] + {{(RC_CW-1){1'b0}}, s[RC_CW]};
    endfunction

    // Maps the second zero code (all ones) onto all zeros.
    function automatic logic [RC_CW-1:0] rc_canon(input logic [RC_CW-1:0] x);
        return (x == {RC_CW{1'b1}}) ? '0 : x;
    endfunction
endpackage

// File: rtl/rsd_alu_core.sv
// Data path of the ALU: ones'-complement add/subtract with end-around carry,
// or a bitwise function of two inputs chosen by a 4-bit truth table.
// Assumes purely combinational use; the top module registers the outputs.
module rsd_alu_core #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          mode_i,
    input  logic [3:0]    fsel_i,
    output logic [DW-1:0] y_o,
    output logic          cout_o
);
    logic [DW:0]   sum_w;
    logic [DW-1:0] b_op;
    logic [DW-1:0] arith_y;
    logic [DW-1:0] logic_y;

    // Operand B, inverted for subtraction.
    always_comb b_op = fsel_i[0] ? ~b_i : b_i;

    // Raw sum, then the end-around carry folded back into bit 0.
    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_op};
        arith_y = sum_w[DW-1:0] + {{(DW-1){1'b0}}, sum_w[DW]};
    end

    // One truth-table lookup per bit, carries disabled.
    for (genvar i = 0; i < DW; i++) begin : g_lbit
        always_comb logic_y[i] = fsel_i[{a_i[i], b_i[i]}];
    end

    // Mode select between the arithmetic and logic results.
    always_comb begin
        y_o    = (mode_i == rsd_pkg::MODE_LOGIC) ? logic_y : arith_y;
        cout_o = (mode_i == rsd_pkg::MODE_LOGIC) ? 1'b0 : sum_w[DW];
    end
endmodule

// File: rtl/rsd_gen.sv
// Residue generator: ones'-complement sum of the data nibbles (modulus 15).
// Output may be either zero code (0000 or 1111); callers normalize as needed.
module rsd_gen #(
    parameter int DW = 16,
    parameter int CW = rsd_pkg::RC_CW
) (
    input  logic [DW-1:0] d_i,
    output logic [CW-1:0] r_o
);
    localparam int NNIB = DW / CW;

    logic [CW-1:0] acc [NNIB+1];

    always_comb acc[0] = '0;

    // Chain of end-around adders, one per nibble.
    for (genvar n = 0; n < NNIB; n++) begin : g_nib
        always_comb acc[n+1] = rsd_pkg::rc_ones_add(acc[n], d_i[n*CW +: CW]);
    end

    always_comb r_o = acc[NNIB];
endmodule

// File: rtl/rsd_predict.sv
// Check-symbol predictor and mode classifier.
// Decides whether the selected operation preserves the residue code and, if so,
// what the result check symbol must be.
module rsd_predict #(
    parameter int CW = rsd_pkg::RC_CW
) (
    input  logic [CW-1:0] a_chk_i,
    input  logic [CW-1:0] b_chk_i,
    input  logic          mode_i,
    input  logic [3:0]    fsel_i,
    output logic [CW-1:0] pred_o,
    output logic          secure_o
);
    import rsd_pkg::*;

    // Secure when arithmetic, or a logic code that preserves the residue.
    always_comb begin
        if (mode_i == MODE_ARITH) secure_o = 1'b1;
        else secure_o = (fsel_i == FN_PASS_A) || (fsel_i == FN_PASS_B) ||
                        (fsel_i == FN_ZERO)   || (fsel_i == FN_ONES);
    end

    // Predicted symbol for each preserving operation.
    always_comb begin
        pred_o = '0;
        if (mode_i == MODE_ARITH) begin
            pred_o = rc_ones_add(a_chk_i, fsel_i[0] ? ~b_chk_i : b_chk_i);
        end else if (fsel_i == FN_PASS_A) begin
            pred_o = a_chk_i;
        end else if (fsel_i == FN_PASS_B) begin
            pred_o = b_chk_i;
        end
    end
endmodule

// File: rtl/rsd_eq_check.sv
// Two-rail equality checker for residue symbols.
// Both zero codes compare equal. When disabled it reports "good" (2'b10).
module rsd_eq_check #(
    parameter int CW = rsd_pkg::RC_CW
) (
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic          en_i,
    output logic [1:0]    rail_o
);
    logic same;

    // Normalized comparison of the two symbols.
    always_comb same = (rsd_pkg::rc_canon(x_i) == rsd_pkg::rc_canon(y_i));

    // Two-rail encoding: 10 good, 01 error.
    always_comb rail_o = (!en_i || same) ? 2'b10 : 2'b01;
endmodule

// File: rtl/rsd_alu.sv
// Residue-checked ALU top. Computes the result, predicts or re-encodes its
// check symbol, compares prediction against generated residue in secure mode,
// and registers all outputs (one-cycle latency). Synchronous active-low reset.
module rsd_alu #(
    parameter int DW = 16,
    parameter int CW = rsd_pkg::RC_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_dat,
    input  logic [CW-1:0] a_chk,
    input  logic [DW-1:0] b_dat,
    input  logic [CW-1:0] b_chk,
    input  logic          op_mode,
    input  logic [3:0]    fsel,
    input  logic [DW-1:0] fault_mask,
    output logic [DW-1:0] y_dat,
    output logic [CW-1:0] y_chk,
    output logic          y_cout,
    output logic [1:0]    err_rail
);
    logic [DW-1:0] raw_y;
    logic [DW-1:0] hit_y;
    logic          raw_cout;
    logic [CW-1:0] gen_r;
    logic [CW-1:0] pred_r;
    logic          secure;
    logic [CW-1:0] chk_nx;
    logic [1:0]    rail_nx;

    rsd_alu_core #(.DW(DW)) u_core (
        .a_i(a_dat), .b_i(b_dat), .mode_i(op_mode), .fsel_i(fsel),
        .y_o(raw_y), .cout_o(raw_cout)
    );

    // Test mask applied ahead of the checking logic.
    always_comb hit_y = raw_y ^ fault_mask;

    rsd_gen #(.DW(DW), .CW(CW)) u_gen (
        .d_i(hit_y), .r_o(gen_r)
    );

    rsd_predict #(.CW(CW)) u_pred (
        .a_chk_i(a_chk), .b_chk_i(b_chk), .mode_i(op_mode), .fsel_i(fsel),
        .pred_o(pred_r), .secure_o(secure)
    );

    rsd_eq_check #(.CW(CW)) u_eq (
        .x_i(pred_r), .y_i(gen_r), .en_i(secure), .rail_o(rail_nx)
    );

    // Output check symbol: prediction when secure, re-encoding otherwise.
    always_comb chk_nx = secure ? pred_r : rsd_pkg::rc_canon(gen_r);

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_dat    <= '0;
            y_chk    <= '0;
            y_cout   <= 1'b0;
            err_rail <= 2'b10;
        end else begin
            y_dat    <= hit_y;
            y_chk    <= chk_nx;
            y_cout   <= raw_cout;
            err_rail <= rail_nx;
        end
    end
endmodule

// File: rtl/rsd_alu_chk.sv
// Assertion checker for rsd_alu, attached by bind. Observes ports only.
module rsd_alu_chk #(
    parameter int DW = 16,
    parameter int CW = rsd_pkg::RC_CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] a_dat,
    input logic [CW-1:0] a_chk,
    input logic [DW-1:0] b_dat,
    input logic [CW-1:0] b_chk,
    input logic          op_mode,
    input logic [3:0]    fsel,
    input logic [DW-1:0] fault_mask,
    input logic [DW-1:0] y_dat,
    input logic [CW-1:0] y_chk,
    input logic          y_cout,
    input logic [1:0]    err_rail
);
    // Residue of a data word as a value 0..14 (modulus arithmetic).
    function automatic logic [CW-1:0] word_res(input logic [DW-1:0] d);
        return CW'(d % 15);
    endfunction

    function automatic logic [DW-1:0] ones_sum(input logic [DW-1:0] x, input logic [DW-1:0] y);
        logic [DW:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[DW-1:0] + {{(DW-1){1'b0}}, s[DW]};
    endfunction

    logic sec_in, ops_valid;
    always_comb begin
        sec_in = !op_mode || (fsel == 4'b1100) || (fsel == 4'b1010) ||
                 (fsel == 4'b0000) || (fsel == 4'b1111);
        ops_valid = (rsd_pkg::rc_canon(a_chk) == word_res(a_dat)) &&
                    (rsd_pkg::rc_canon(b_chk) == word_res(b_dat));
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (y_dat == '0 && y_chk == '0 && !y_cout && err_rail == 2'b10));

    p_add_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_mode && !fsel[0] && fault_mask == '0) |=> y_dat == ones_sum($past(a_dat), $past(b_dat)));

    p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode |=> !y_cout);

    p_reencode_canon_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_in |=> (y_chk == word_res(y_dat)));

    p_clean_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_in && ops_valid && fault_mask == '0) |=> err_rail == 2'b10);

    p_flip_caught_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_in && ops_valid && $onehot(fault_mask)) |=> err_rail == 2'b01);

    p_insecure_good_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_in |=> err_rail == 2'b10);
endmodule

bind rsd_alu rsd_alu_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_dat(a_dat), .a_chk(a_chk), .b_dat(b_dat),
    .b_chk(b_chk), .op_mode(op_mode), .fsel(fsel), .fault_mask(fault_mask),
    .y_dat(y_dat), .y_chk(y_chk), .y_cout(y_cout), .err_rail(err_rail)
);

// File: tb/tb_rsd_alu.sv
`timescale 1ns/1ps
module tb_rsd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_dat = '0, b_dat = '0, fault_mask = '0;
    logic [3:0]  a_chk = '0, b_chk = '0, fsel = '0;
    logic        op_mode = 1'b0;
    logic [15:0] y_dat;
    logic [3:0]  y_chk;
    logic        y_cout;
    logic [1:0]  err_rail;
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    rsd_alu dut (
        .clk(clk), .rst_n(rst_n), .a_dat(a_dat), .a_chk(a_chk), .b_dat(b_dat),
        .b_chk(b_chk), .op_mode(op_mode), .fsel(fsel), .fault_mask(fault_mask),
        .y_dat(y_dat), .y_chk(y_chk), .y_cout(y_cout), .err_rail(err_rail)
    );

    // ---- reference model from the requirements ----
    function automatic logic [3:0] m_res(input logic [15:0] d);
        return 4'(d % 15);
    endfunction
    function automatic logic [3:0] m_add4(input logic [3:0] x, input logic [3:0] y);
        int s;
        s = int'(x) + int'(y);
        return 4'((s & 15) + (s >> 4));
    endfunction
    function automatic logic [16:0] m_add16(input logic [15:0] x, input logic [15:0] y);
        int s;
        s = int'(x) + int'(y);
        return {1'(s >> 16), 16'((s & 16'hFFFF) + (s >> 16))};
    endfunction
    function automatic logic [15:0] m_logic(input logic [3:0] f, input logic [15:0] x, input logic [15:0] y);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = f[{x[i], y[i]}];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operation and wait until its registered result is visible.
    task automatic run_op(input logic m, input logic [3:0] f, input logic [15:0] a, input logic [3:0] ac,
                          input logic [15:0] b, input logic [3:0] bc, input logic [15:0] mask);
        @(negedge clk);
        op_mode = m; fsel = f; a_dat = a; a_chk = ac; b_dat = b; b_chk = bc; fault_mask = mask;
        @(negedge clk);
    endtask

    task automatic t_reset();
        run_op(1'b0, 4'b0000, 16'h1234, m_res(16'h1234), 16'h0F0F, m_res(16'h0F0F), 16'h0);
        check("R1 y_dat", 32'(y_dat), 32'h0);
        check("R1 y_chk", 32'(y_chk), 32'h0);
        check("R1 y_cout", 32'(y_cout), 32'h0);
        check("R1 rail", 32'(err_rail), 32'h2);
    endtask

    task automatic t_arith_corner();
        // End-around carry: FFFF + 0001 = 0001 with carry
        run_op(1'b0, 4'b0000, 16'hFFFF, 4'h0, 16'h0001, 4'h1, 16'h0);
        check("R2 wrap y", 32'(y_dat), 32'h0001);
        check("R2 wrap cout", 32'(y_cout), 32'h1);
        check("R7 wrap rail", 32'(err_rail), 32'h2);
        // Checks 7 and 8 predict 1111 which must compare equal to zero residue
        run_op(1'b0, 4'b0000, 16'h0007, 4'h7, 16'h0008, 4'h8, 16'h0);
        check("R11 y", 32'(y_dat), 32'h000F);
        check("R11 chk", 32'(y_chk), 32'hF);
        check("R11 rail", 32'(err_rail), 32'h2);
        // A - A gives negative zero FFFF
        run_op(1'b0, 4'b0001, 16'h5A3C, m_res(16'h5A3C), 16'h5A3C, m_res(16'h5A3C), 16'h0);
        check("R3 negzero y", 32'(y_dat), 32'hFFFF);
        check("R3 negzero cout", 32'(y_cout), 32'h0);
        check("R3 negzero rail", 32'(err_rail), 32'h2);
    endtask

    task automatic t_random_arith();
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a, b, bop;
            logic [16:0] e;
            logic sub;
            a = 16'($urandom); b = 16'($urandom); sub = 1'($urandom);
            bop = sub ? ~b : b;
            e = m_add16(a, bop);
            run_op(1'b0, {3'b000, sub}, a, m_res(a), b, m_res(b), 16'h0);
            check(sub ? "R3 rand y" : "R2 rand y", 32'(y_dat), 32'(e[15:0]));
            check(sub ? "R3 rand cout" : "R2 rand cout", 32'(y_cout), 32'(e[16]));
            check("R5 rand chk", 32'(y_chk),
                  32'(m_add4(m_res(a), sub ? ~m_res(b) : m_res(b))));
            check("R7 rand rail", 32'(err_rail), 32'h2);
        end
    endtask

    task automatic t_ignored_sel();
        logic [16:0] e;
        e = m_add16(16'h8421, ~16'h1248);
        run_op(1'b0, 4'b1111, 16'h8421, m_res(16'h8421), 16'h1248, m_res(16'h1248), 16'h0);
        check("R3 sel hi ignored sub y", 32'(y_dat), 32'(e[15:0]));
        check("R3 sel hi ignored sub rail", 32'(err_rail), 32'h2);
        e = m_add16(16'h8421, 16'h1248);
        run_op(1'b0, 4'b0110, 16'h8421, m_res(16'h8421), 16'h1248, m_res(16'h1248), 16'h0);
        check("R3 sel hi ignored add y", 32'(y_dat), 32'(e[15:0]));
        check("R3 sel hi ignored add cout", 32'(y_cout), 32'(e[16]));
    endtask

    task automatic t_logic_secure();
        logic [15:0] a, b;
        a = 16'hC3A5; b = 16'h0FF1;
        run_op(1'b1, 4'b1100, a, m_res(a), b, m_res(b), 16'h0);
        check("R4 passA y", 32'(y_dat), 32'(a));
        check("R5 passA chk", 32'(y_chk), 32'(m_res(a)));
        check("R7 passA rail", 32'(err_rail), 32'h2);
        run_op(1'b1, 4'b1010, a, m_res(a), b, m_res(b), 16'h0);
        check("R4 passB y", 32'(y_dat), 32'(b));
        check("R5 passB chk", 32'(y_chk), 32'(m_res(b)));
        run_op(1'b1, 4'b0000, a, m_res(a), b, m_res(b), 16'h0);
        check("R4 zero y", 32'(y_dat), 32'h0);
        check("R5 zero chk", 32'(y_chk), 32'h0);
        run_op(1'b1, 4'b1111, a, m_res(a), b, m_res(b), 16'h0);
        check("R4 ones y", 32'(y_dat), 32'hFFFF);
        check("R5 ones chk", 32'(y_chk), 32'h0);
        check("R4 ones cout", 32'(y_cout), 32'h0);
        check("R7 ones rail", 32'(err_rail), 32'h2);
    endtask

    task automatic t_logic_insecure();
        logic [3:0] fns [3];
        logic [15:0] a, b, e;
        fns[0] = 4'b1000; fns[1] = 4'b1110; fns[2] = 4'b0110;
        a = 16'hF0E1; b = 16'hFF0F;
        for (int k = 0; k < 3; k++) begin
            e = m_logic(fns[k], a, b);
            run_op(1'b1, fns[k], a, m_res(a), b, m_res(b), 16'h0);
            check("R4 insecure y", 32'(y_dat), 32'(e));
            check("R6 reencode chk", 32'(y_chk), 32'(m_res(e)));
            check("R10 insecure rail", 32'(err_rail), 32'h2);
        end
        // OR yielding FFFF must re-encode as 0000, never 1111
        run_op(1'b1, 4'b1110, 16'hFF00, 4'h0, 16'h00FF, 4'h0, 16'h0);
        check("R6 canon y", 32'(y_dat), 32'hFFFF);
        check("R6 canon chk", 32'(y_chk), 32'h0);
    endtask

    task automatic t_fault_secure();
        logic [16:0] e;
        e = m_add16(16'h1357, 16'h2468);
        for (int k = 0; k < 16; k++) begin
            run_op(1'b0, 4'b0000, 16'h1357, m_res(16'h1357), 16'h2468, m_res(16'h2468), 16'(1) << k);
            check("R8 flip y", 32'(y_dat), 32'(e[15:0] ^ (16'(1) << k)));
            check("R8 flip rail", 32'(err_rail), 32'h1);
        end
        run_op(1'b1, 4'b1100, 16'hABCD, m_res(16'hABCD), 16'h0, 4'h0, 16'h0100);
        check("R8 passA flip rail", 32'(err_rail), 32'h1);
    endtask

    task automatic t_fault_insecure();
        logic [15:0] e;
        e = m_logic(4'b1000, 16'h7777, 16'h3C3C) ^ 16'h0040;
        run_op(1'b1, 4'b1000, 16'h7777, m_res(16'h7777), 16'h3C3C, m_res(16'h3C3C), 16'h0040);
        check("R10 masked y", 32'(y_dat), 32'(e));
        check("R10 masked chk", 32'(y_chk), 32'(m_res(e)));
        check("R10 masked rail", 32'(err_rail), 32'h2);
    endtask

    task automatic t_bad_operand();
        run_op(1'b0, 4'b0000, 16'h0123, m_res(16'h0123) ^ 4'h2, 16'h0456, m_res(16'h0456), 16'h0);
        check("R9 bad a_chk rail", 32'(err_rail), 32'h1);
        run_op(1'b0, 4'b0001, 16'h0123, m_res(16'h0123), 16'h0456, m_res(16'h0456) ^ 4'h8, 16'h0);
        check("R9 bad b_chk rail", 32'(err_rail), 32'h1);
        run_op(1'b0, 4'b0000, 16'h0123, m_res(16'h0123), 16'h0456, m_res(16'h0456), 16'h0);
        check("R7 recovered rail", 32'(err_rail), 32'h2);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_arith_corner();
        t_random_arith();
        t_ignored_sel();
        t_logic_secure();
        t_logic_insecure();
        t_fault_secure();
        t_fault_insecure();
        t_bad_operand();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1-all: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule